// File: doc/BRIEF.md
# Dual Clock-Source Select Controller

This block oversees two on-chip clock generators and the single select bit that decides which of them feeds the core. Software writes one control word. For each generator, the word holds a 5-bit multiplier code, a 2-bit range code and a power-down bit. The word also holds the source select. The block does not build clocks itself. It drives the settings to the generators and the select to an external glitch-free mux. It also models each generator's lock time as a programmable count of cycles.

Each write is checked against ordering rules before it takes effect:

- the running source must not be retuned;
- a source must be locked and powered before it is chosen;
- the select may not hop directly between two half-step multiplier modes;
- range codes must be legal.

A write that breaks any rule changes nothing. It only raises the matching sticky error flags, which software clears by writing ones to them.

Top module: `clksel_ctrl`

## Requirements
- R1: After synchronous reset the control word reads select 0. Generator 0 reads powered, range 00, multiplier RST_CFG. Generator 1 reads powered down, range 00, multiplier RST_CFG. All error flags are 0 and both locked outputs are 0.
- R2: An accepted write that changes a generator's multiplier, range or power-down bit restarts its lock timer. That generator's locked output rises exactly LOCK_CYC clock edges after the write edge. The timer also restarts when the generator first leaves reset. A powered-down generator never reads locked.
- R3: When the target generator is already locked, a write that only flips the select is accepted, and sel_o follows on the very next edge with no wait.
- R4: Error bit 0 is set and the write is rejected when it would change the multiplier or range of the currently selected generator.
- R5: Error bit 1 is set and the write is rejected when it would change the power-down bit of the currently selected generator.
- R6: Error bit 2 is set and the write is rejected when it flips the select while either of two things holds. The target generator is not locked, or the same write also changes any field of the target.
- R7: Error bit 3 is set and the write is rejected when it flips the select toward a generator whose power-down bit would be 1.
- R8: A multiplier code is half-step when bits [4:3] are 01 and bit 0 is 1, for example 01001 and 01101. Error bit 4 is set and the write is rejected when it flips the select while both written multiplier codes are half-step.
- R9: Range code 00 means 600 MHz and above and 10 means below 600 MHz. Codes with bit 0 set (01, 11) are reserved, and writing one sets error bit 5 and rejects the write.
- R10: A rejected write leaves the control word and lock timers unchanged. Every rule that the write breaks sets its own bit in the same edge.
- R11: Error bits are sticky. A 1 on err_clr clears the matching bit. If a new violation of the same rule occurs in the same cycle, the set wins.
- R12: Word layout, for wr_data and ctrl_o:
  - bit 0 is the select: 0 means generator 0, 1 means generator 1.
  - Generator 0 uses bits [5:1] multiplier, [7:6] range and [8] power-down.
  - Generator 1 uses [13:9] multiplier, [15:14] range and [16] power-down.
  - pll_on_o[p] is the inverse of generator p's power-down bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 17 | Proposed control word |
| err_clr | input | 6 | Write-one-to-clear mask for error flags |
| ctrl_o | output | 17 | Current accepted control word |
| sel_o | output | 1 | Active source select |
| pll_on_o | output | 2 | Per-generator enable |
| locked_o | output | 2 | Per-generator lock flag |
| err_o | output | 6 | Sticky rule-violation flags |

## Verification
A rule violation setting an error flag and a software clear of that same flag can land on one edge. The bench provokes this by driving a rejected half-step switch together with err_clr on the same bit, and expects the flag to remain set. It then expects a lone clear to drop it. Several rules can also fire from one write, and the bench judges this against a behavioural model. That model recomputes the violation set, the accepted word and each lock age on every clock. All outputs are compared at each falling edge, through both directed cases and a run of mutated random writes.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int CFG_W = 5;
  localparam int RNG_W = 2;
  localparam int NPLL  = 2;
  localparam int ERR_W = 6;

  // error flag positions
  localparam int E_ACT_CFG = 0;
  localparam int E_ACT_PD  = 1;
  localparam int E_UNLOCK  = 2;
  localparam int E_OFF     = 3;
  localparam int E_HALF    = 4;
  localparam int E_RNG     = 5;

  typedef struct packed {
    logic             pd;
    logic [RNG_W-1:0] rng;
    logic [CFG_W-1:0] cfg;
  } pll_fld_t;

  localparam int FLD_W = $bits(pll_fld_t);
  localparam int CW_W  = 1 + NPLL * FLD_W;

  typedef struct packed {
    pll_fld_t p1;
    pll_fld_t p0;
    logic     sel;
  } ctrl_word_t;

  // half-step multiplier: top pair 01 and odd
  function automatic logic is_half(input logic [CFG_W-1:0] c);
    return (c[CFG_W-1:CFG_W-2] == 2'b01) && c[0];
  endfunction

  function automatic logic rng_bad(input logic [RNG_W-1:0] r);
    return r[0];
  endfunction
endpackage

// File: rtl/clksel_lock_timer.sv
module clksel_lock_timer #(
  parameter int LOCK_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic pd,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOCK_CYC);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             lk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LOAD;
      lk_q  <= 1'b0;
    end else if (restart || pd) begin
      cnt_q <= LOAD;
      lk_q  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
      lk_q  <= (cnt_q == ONE);
    end else begin
      lk_q  <= 1'b1;
    end
  end

  assign locked = lk_q;
endmodule

// File: rtl/clksel_rule_chk.sv
module clksel_rule_chk
  import clksel_pkg::*;
(
  input  ctrl_word_t            cur,
  input  ctrl_word_t            nxt,
  input  logic [NPLL-1:0]       locked,
  output logic [ERR_W-1:0]      viol,
  output logic [NPLL-1:0]       fld_chg
);
  pll_fld_t cf [NPLL];
  pll_fld_t nf [NPLL];
  logic [NPLL-1:0] tune_chg;
  logic [NPLL-1:0] pd_chg;
  logic sel_flip;

  assign cf[0] = cur.p0;
  assign cf[1] = cur.p1;
  assign nf[0] = nxt.p0;
  assign nf[1] = nxt.p1;

  for (genvar g = 0; g < NPLL; g++) begin : g_chg
    assign tune_chg[g] = (cf[g].cfg != nf[g].cfg) || (cf[g].rng != nf[g].rng);
    assign pd_chg[g]   = (cf[g].pd != nf[g].pd);
    assign fld_chg[g]  = tune_chg[g] | pd_chg[g];
  end

  assign sel_flip = cur.sel ^ nxt.sel;

  always_comb begin
    viol = '0;
    viol[E_ACT_CFG] = tune_chg[cur.sel];
    viol[E_ACT_PD]  = pd_chg[cur.sel];
    viol[E_UNLOCK]  = sel_flip && (!locked[nxt.sel] || fld_chg[nxt.sel]);
    viol[E_OFF]     = sel_flip && nf[nxt.sel].pd;
    viol[E_HALF]    = sel_flip && is_half(nf[0].cfg) && is_half(nf[1].cfg);
    viol[E_RNG]     = rng_bad(nf[0].rng) || rng_bad(nf[1].rng);
  end
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int               LOCK_CYC = 16,
  parameter logic [CFG_W-1:0] RST_CFG  = 5'b10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CW_W-1:0]   wr_data,
  input  logic [ERR_W-1:0]  err_clr,
  output logic [CW_W-1:0]   ctrl_o,
  output logic              sel_o,
  output logic [NPLL-1:0]   pll_on_o,
  output logic [NPLL-1:0]   locked_o,
  output logic [ERR_W-1:0]  err_o
);
  localparam ctrl_word_t RST_WORD =
    ctrl_word_t'({1'b1, {RNG_W{1'b0}}, RST_CFG, 1'b0, {RNG_W{1'b0}}, RST_CFG, 1'b0});

  ctrl_word_t        ctrl_q, wr_w, ctrl_nxt;
  logic [ERR_W-1:0]  viol, err_q;
  logic [NPLL-1:0]   fld_chg, restart, pd_nxt, lk;
  logic              accept;

  assign wr_w = ctrl_word_t'(wr_data);

  clksel_rule_chk u_rules (
    .cur     (ctrl_q),
    .nxt     (wr_w),
    .locked  (lk),
    .viol    (viol),
    .fld_chg (fld_chg)
  );

  assign accept   = wr_en && (viol == '0);
  assign ctrl_nxt = accept ? wr_w : ctrl_q;
  assign pd_nxt   = {ctrl_nxt.p1.pd, ctrl_nxt.p0.pd};
  assign restart  = {NPLL{accept}} & fld_chg;

  for (genvar g = 0; g < NPLL; g++) begin : g_pll
    clksel_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .restart (restart[g]),
      .pd      (pd_nxt[g]),
      .locked  (lk[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RST_WORD;
      err_q  <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      err_q  <= (err_q & ~err_clr) | (wr_en ? viol : '0);
    end
  end

  assign ctrl_o   = ctrl_q;
  assign sel_o    = ctrl_q.sel;
  assign pll_on_o = ~{ctrl_q.p1.pd, ctrl_q.p0.pd};
  assign locked_o = lk;
  assign err_o    = err_q;
endmodule

// File: rtl/clksel_chk.sv
module clksel_chk
  import clksel_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [ERR_W-1:0] err_clr,
  input logic [CW_W-1:0]  ctrl_o,
  input logic             sel_o,
  input logic [NPLL-1:0]  pll_on_o,
  input logic [NPLL-1:0]  locked_o,
  input logic [ERR_W-1:0] err_o
);
  ctrl_word_t cw;
  assign cw = ctrl_word_t'(ctrl_o);

  AST_OFF0_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !pll_on_o[0] |-> !locked_o[0]);  // R2
  AST_OFF1_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !pll_on_o[1] |-> !locked_o[1]);  // R2
  AST_ACT0_TUNE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(sel_o) |-> ($stable(cw.p0.cfg) && $stable(cw.p0.rng)));  // R4
  AST_ACT1_TUNE_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(sel_o) |-> ($stable(cw.p1.cfg) && $stable(cw.p1.rng)));  // R4
  AST_ACT0_PD_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(sel_o) |-> $stable(cw.p0.pd));  // R5
  AST_ACT1_PD_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(sel_o) |-> $stable(cw.p1.pd));  // R5
  AST_RISE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_o) |-> $past(locked_o[1]));  // R6
  AST_FALL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_o) |-> $past(locked_o[0]));  // R6
  AST_SEL_POWERED: assert property (@(posedge clk) disable iff (rst)
    (sel_o ? pll_on_o[1] : pll_on_o[0]));  // R7
  AST_NO_HALF_HOP: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_o) |-> !(is_half(cw.p0.cfg) && is_half(cw.p1.cfg)));  // R8
  AST_NO_RSV_RANGE: assert property (@(posedge clk) disable iff (rst)
    !rng_bad(cw.p0.rng) && !rng_bad(cw.p1.rng));  // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((err_o & $past(err_o & ~err_clr)) == $past(err_o & ~err_clr)));  // R11
endmodule

bind clksel_ctrl clksel_chk u_clksel_chk (
  .clk      (clk),
  .rst      (rst),
  .err_clr  (err_clr),
  .ctrl_o   (ctrl_o),
  .sel_o    (sel_o),
  .pll_on_o (pll_on_o),
  .locked_o (locked_o),
  .err_o    (err_o)
);

// File: tb/tb_clksel_ctrl.sv
module tb_clksel_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LK = 12;
  localparam logic [4:0] RC  = 5'b10000;
  localparam logic [4:0] F61 = 5'b00110;
  localparam logic [4:0] H1  = 5'b01001;
  localparam logic [4:0] H2  = 5'b01101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [16:0] wr_data = '0;
  logic [5:0] err_clr = '0;
  logic [16:0] ctrl_o;
  logic sel_o;
  logic [1:0] pll_on_o, locked_o;
  logic [5:0] err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clksel_ctrl #(.LOCK_CYC(LK), .RST_CFG(RC)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .err_clr(err_clr),
    .ctrl_o(ctrl_o), .sel_o(sel_o), .pll_on_o(pll_on_o), .locked_o(locked_o), .err_o(err_o)
  );

  // ---------------- reference model ----------------
  logic       m_sel;
  logic [4:0] m_cfg [2];
  logic [1:0] m_rng [2];
  logic       m_pd  [2];
  int         m_age [2];
  logic [5:0] m_err;

  function automatic logic [16:0] mk(input logic s, input logic [4:0] c0, input logic [1:0] r0,
      input logic p0, input logic [4:0] c1, input logic [1:0] r1, input logic p1);
    return {p1, r1, c1, p0, r0, c0, s};
  endfunction

  function automatic logic half_code(input logic [4:0] c);
    return (c[4:3] == 2'b01) && (c[0] == 1'b1);
  endfunction

  function automatic logic m_locked(input int p);
    return !m_pd[p] && (m_age[p] >= LK);
  endfunction

  function automatic logic [16:0] m_word();
    return mk(m_sel, m_cfg[0], m_rng[0], m_pd[0], m_cfg[1], m_rng[1], m_pd[1]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_cfg[0] = RC; m_cfg[1] = RC; m_rng[0] = 0; m_rng[1] = 0;
      m_pd[0] = 0; m_pd[1] = 1; m_age[0] = 0; m_age[1] = 0; m_err = 0;
    end else begin
      logic [5:0] v;
      logic ns;
      logic [4:0] nc [2];
      logic [1:0] nr [2];
      logic np [2];
      bit tch [2];
      bit pch [2];
      int s, t;
      v = 0;
      ns = wr_data[0];
      for (int p = 0; p < 2; p++) begin
        nc[p] = wr_data[p*8+1 +: 5];
        nr[p] = wr_data[p*8+6 +: 2];
        np[p] = wr_data[p*8+8];
        tch[p] = (nc[p] != m_cfg[p]) || (nr[p] != m_rng[p]);
        pch[p] = (np[p] != m_pd[p]);
      end
      s = int'(m_sel);
      t = int'(ns);
      if (wr_en) begin
        if (tch[s]) v[0] = 1;
        if (pch[s]) v[1] = 1;
        if (t != s) begin
          if (!m_locked(t) || tch[t] || pch[t]) v[2] = 1;
          if (np[t]) v[3] = 1;
          if (half_code(nc[0]) && half_code(nc[1])) v[4] = 1;
        end
        if (nr[0][0] || nr[1][0]) v[5] = 1;
      end
      m_err = (m_err & ~err_clr) | v;
      for (int p = 0; p < 2; p++) begin
        if (wr_en && v == 0 && (tch[p] || pch[p])) m_age[p] = 0;
        else if (m_age[p] < LK) m_age[p] = m_age[p] + 1;
      end
      if (wr_en && v == 0) begin
        m_sel = ns;
        for (int p = 0; p < 2; p++) begin
          m_cfg[p] = nc[p]; m_rng[p] = nr[p]; m_pd[p] = np[p];
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 control word vs model", 32'(ctrl_o), 32'(m_word()));
      chk("R3 select vs model", 32'(sel_o), 32'(m_sel));
      chk("R2 locked vs model", 32'(locked_o), 32'({m_locked(1), m_locked(0)}));
      chk("R11 errors vs model", 32'(err_o), 32'(m_err));
      chk("R12 enables vs model", 32'(pll_on_o), 32'({!m_pd[1], !m_pd[0]}));
    end
  end

  task automatic wr(input logic [16:0] w);
    wr_en = 1; wr_data = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic clr(input logic [5:0] b);
    err_clr = b;
    @(negedge clk);
    err_clr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [16:0] w;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 reset word", 32'(ctrl_o), 32'(mk(0, RC, 0, 0, RC, 0, 1)));
    chk("R1 reset errors", 32'(err_o), 0);
    chk("R1 reset locked", 32'(locked_o), 0);
    chk("R12 reset enables", 32'(pll_on_o), 32'h1);
    // R2 initial lock after LK edges
    repeat (LK - 1) @(negedge clk);
    chk("R2 not yet locked", 32'(locked_o[0]), 0);
    @(negedge clk);
    chk("R2 locked at LK", 32'(locked_o[0]), 1);
    // R7/R6 select an off generator
    wr(mk(1, RC, 0, 0, RC, 0, 1));
    chk("R7 R6 select off", 32'(err_o), 32'h0C);
    chk("R7 select held", 32'(sel_o), 0);
    clr(6'h3F);
    // turn generator 1 on, exact lock timing
    wr(mk(0, RC, 0, 0, F61, 2'b10, 0));
    chk("R2 power-up accepted", 32'(err_o), 0);
    repeat (LK - 1) @(negedge clk);
    chk("R2 gen1 before lock", 32'(locked_o[1]), 0);
    @(negedge clk);
    chk("R2 gen1 locked", 32'(locked_o[1]), 1);
    // R4 retune active
    wr(mk(0, 5'b10001, 0, 0, F61, 2'b10, 0));
    chk("R4 retune active", 32'(err_o), 32'h01);
    chk("R10 word kept", 32'(ctrl_o), 32'(mk(0, RC, 0, 0, F61, 2'b10, 0)));
    clr(6'h3F);
    // R5 power-down active
    wr(mk(0, RC, 0, 1, F61, 2'b10, 0));
    chk("R5 pd active", 32'(err_o), 32'h02);
    clr(6'h3F);
    // R9 reserved range
    wr(mk(0, RC, 0, 0, F61, 2'b01, 0));
    chk("R9 reserved range", 32'(err_o), 32'h20);
    chk("R10 word kept rng", 32'(ctrl_o), 32'(mk(0, RC, 0, 0, F61, 2'b10, 0)));
    clr(6'h3F);
    // R3 quick toggles
    wr(mk(1, RC, 0, 0, F61, 2'b10, 0));
    chk("R3 switch to 1", 32'(sel_o), 1);
    wr(mk(0, RC, 0, 0, F61, 2'b10, 0));
    chk("R3 switch back no wait", 32'(sel_o), 0);
    chk("R3 no errors", 32'(err_o), 0);
    wr(mk(1, RC, 0, 0, F61, 2'b10, 0));
    // power generator 0 down while 1 is active
    wr(mk(1, RC, 0, 1, F61, 2'b10, 0));
    chk("R2 off drops lock", 32'(locked_o[0]), 0);
    chk("R12 gen0 disabled", 32'(pll_on_o), 32'h2);
    wr(mk(0, RC, 0, 1, F61, 2'b10, 0));
    chk("R7 select off gen0", 32'(err_o), 32'h0C);
    clr(6'h3F);
    // R8 half-step pair
    wr(mk(1, H1, 0, 0, F61, 2'b10, 0));
    repeat (LK + 1) @(negedge clk);
    wr(mk(0, H1, 0, 0, F61, 2'b10, 0));
    chk("R8 half to full ok", 32'(sel_o), 0);
    wr(mk(0, H1, 0, 0, H2, 2'b10, 0));
    repeat (LK + 1) @(negedge clk);
    wr(mk(1, H1, 0, 0, H2, 2'b10, 0));
    chk("R8 half pair", 32'(err_o), 32'h10);
    chk("R8 select held", 32'(sel_o), 0);
    // R11 set wins over clear in same cycle
    err_clr = 6'h10;
    wr(mk(1, H1, 0, 0, H2, 2'b10, 0));
    chk("R11 set wins", 32'(err_o), 32'h10);
    clr(6'h10);
    chk("R11 cleared", 32'(err_o), 0);
    // R10 several rules at once
    wr(mk(1, 5'b10001, 2'b11, 1, H2, 2'b10, 0));
    chk("R10 multi rule", 32'(err_o), 32'h23);
    chk("R10 word kept multi", 32'(ctrl_o), 32'(mk(0, H1, 0, 0, H2, 2'b10, 0)));
    clr(6'h3F);
    // R6 retune target in the switching write
    wr(mk(1, H1, 0, 0, F61, 2'b10, 0));
    chk("R6 target touched", 32'(err_o), 32'h04);
    clr(6'h3F);
    // random mutated writes, model compared every clock
    for (int i = 0; i < 600; i++) begin
      int r;
      int p;
      logic [4:0] c;
      w = m_word();
      r = $urandom % 7;
      p = $urandom % 2;
      case ($urandom % 4)
        0: c = H1;
        1: c = H2;
        2: c = F61;
        default: c = 5'($urandom);
      endcase
      case (r)
        0: w[0] = ~w[0];
        1: w[p*8+1 +: 5] = c;
        2: w[p*8+8] = ~w[p*8+8];
        3: w[p*8+6 +: 2] = 2'($urandom);
        4: begin w[0] = ~w[0]; w[p*8+1 +: 5] = c; end
        default: ;
      endcase
      err_clr = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
      wr_en = (r != 6);
      wr_data = w;
      @(negedge clk);
    end
    wr_en = 0;
    err_clr = 0;
    @(negedge clk);
    finish_run();
  end
endmodule